// File: doc/BRIEF.md
# CRC-Protected Rate-Bridging Link Transmitter

This block takes trigger data words from a slow fabric clock domain, about 80 MHz, and hands them to a faster link clock domain, about 150 MHz. The link clock comes from its own oscillator, so the two clocks have no fixed phase relation. A frame opens with a word flagged as bunch-crossing-zero (BC0) and holds a fixed number of data words. In the slow domain the block computes a CRC-16 over those words and writes the checksum word directly behind the last one.

The words cross into the link domain one whole word at a time through a small dual-port buffer. Its pointers are Gray coded and synchronised with flop chains. In every link-clock cycle the block emits one word. If the buffer holds a word, that word goes out with its enable flag set. If the buffer is empty, a comma padding word goes out, which the receiver recognises and discards. Because padding absorbs the rate mismatch, no elastic buffer is needed. The serialiser and line coding follow this block and are not part of it.

Top module: `crc_link_tx`

## Requirements
- R1: While either domain is in reset, and afterwards until a word has been accepted, the outputs are out_valid=0, out_comma=1 and out_data equal to COMMA_WORD (default 16'h50BC).
- R2: In every link-clock cycle out_valid and out_comma are complementary. A word with out_comma=1 always carries COMMA_WORD on out_data.
- R3: Each accepted 16-bit data word appears once on out_data with out_valid=1. It is unchanged and keeps its order relative to the other accepted words. No other word appears with out_valid=1.
- R4: A frame is FRAME_LEN (default 4) accepted data words. Exactly one checksum word follows it, directly after the last data word.
- R5: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. Each word is fed most significant bit first, with no bit reflection and no final inversion. The checksum covers the frame's data words in order.
- R6: out_bc0 is 1 only on the data word that opened its frame with in_bc0=1. out_crc is 1 only on checksum words, and never on the same word as out_bc0.
- R7: A word with in_valid=1 and in_bc0=0 that arrives while no frame is open is dropped.
- R8: The slow cycle after a frame's last data word is reserved for the checksum. Any word offered in that cycle is dropped, even one with in_bc0=1.
- R9: A word with in_valid=1 and in_bc0=1 that arrives while a frame is open abandons that frame. No checksum is sent for it, and the word opens a new frame.
- R10: The buffer is never written while it is full, given that the link clock is faster than the fabric clock.
- R11: Whenever the buffer is empty the next output word is padding, so the output returns to commas once input stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_s | input | 1 | Slow fabric clock |
| rst_s_n | input | 1 | Asynchronous active-low reset, slow domain |
| in_valid | input | 1 | Input word present |
| in_bc0 | input | 1 | Input word opens a frame |
| in_data | input | 16 | Input data word |
| clk_f | input | 1 | Fast link clock |
| rst_f_n | input | 1 | Asynchronous active-low reset, fast domain |
| out_data | output | 16 | Output word: data, checksum or comma |
| out_valid | output | 1 | Output word carries data or checksum |
| out_comma | output | 1 | Output word is padding |
| out_bc0 | output | 1 | Output word opened its frame |
| out_crc | output | 1 | Output word is a checksum |

## Verification
The bench targets the following corner cases:
- A stray word before any frame. A design that opens frames without BC0 would leak it onto the link.
- A word, and later a BC0 word, offered in the checksum slot. A design that lets either through would emit an extra word or lose the checksum.
- A BC0 arriving in the middle of a frame. A design that closes the old frame would emit a checksum for it.
- All-zero and all-one payloads. These expose a wrong CRC seed or bit order.
- A gap inside a frame. This catches a design that counts cycles rather than words.

Comma integrity and the return to padding are checked on every link cycle.

// File: rtl/crc_link_tx_pkg.sv
package crc_link_tx_pkg;

  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [DATA_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic              bc0;
    logic              is_crc;
    logic [DATA_W-1:0] data;
  } link_word_t;

  localparam int WORD_W = $bits(link_word_t);

  // One data word folded into the running checksum, MSB first.
  function automatic logic [DATA_W-1:0] crc_fold(input logic [DATA_W-1:0] crc_in,
                                                 input logic [DATA_W-1:0] word);
    logic [DATA_W-1:0] c;
    logic              fb;
    c = crc_in;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[DATA_W-1] ^ word[i];
      c  = {c[DATA_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/clt_rst_sync.sv
module clt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/clt_gray_sync.sv
module clt_gray_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/clt_framer.sv
module clt_framer
  import crc_link_tx_pkg::*;
#(
  parameter int FRAME_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bc0,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_en,
  output link_word_t        wr_word
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic             ONE_WORD = (FRAME_LEN == 1);

  logic              open_q, open_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] crc_q, crc_d;
  logic              wr_q, wr_d;
  link_word_t        word_q, word_d;

  always_comb begin
    open_d = open_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    wr_d   = 1'b0;
    word_d = '0;
    if (pend_q) begin
      // reserved checksum slot: input is ignored
      wr_d           = 1'b1;
      word_d.is_crc  = 1'b1;
      word_d.data    = crc_q;
      pend_d         = 1'b0;
      crc_d          = CRC_SEED;
    end else if (in_valid && in_bc0) begin
      wr_d        = 1'b1;
      word_d.bc0  = 1'b1;
      word_d.data = in_data;
      crc_d       = crc_fold(CRC_SEED, in_data);
      cnt_d       = CNT_W'(1);
      open_d      = !ONE_WORD;
      pend_d      = ONE_WORD;
    end else if (in_valid && open_q) begin
      wr_d        = 1'b1;
      word_d.data = in_data;
      crc_d       = crc_fold(crc_q, in_data);
      cnt_d       = cnt_q + CNT_W'(1);
      if (cnt_q == LAST_IDX) begin
        open_d = 1'b0;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= CRC_SEED;
      wr_q   <= 1'b0;
      word_q <= '0;
    end else begin
      open_q <= open_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
      wr_q   <= wr_d;
      word_q <= word_d;
    end
  end

  assign wr_en   = wr_q;
  assign wr_word = word_q;

endmodule

// File: rtl/clt_async_fifo.sv
module clt_async_fifo #(
  parameter int DW          = 18,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rgray_w;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wgray_r;
  logic          wr_go, rd_go;

  // write side
  assign wr_full = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign wr_go   = wr_en && !wr_full;

  always_comb begin
    wbin_d  = wbin_q + (wr_go ? PW'(1) : PW'(0));
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  clt_gray_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );

  // read side
  assign rd_empty = (rgray_q == wgray_r);
  assign rd_go    = rd_en && !rd_empty;
  assign rd_data  = mem[rbin_q[AW-1:0]];

  always_comb begin
    rbin_d  = rbin_q + (rd_go ? PW'(1) : PW'(0));
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  clt_gray_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );

endmodule

// File: rtl/clt_pad_out.sv
module clt_pad_out
  import crc_link_tx_pkg::*;
#(
  parameter logic [DATA_W-1:0] COMMA_WORD = 16'h50BC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              empty,
  input  link_word_t        word,
  output logic              rd_en,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_comma,
  output logic              out_bc0,
  output logic              out_crc
);

  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_d, valid_q, comma_d, comma_q;
  logic              bc0_d, bc0_q, crc_d, crc_q;

  assign rd_en = !empty;

  always_comb begin
    if (!empty) begin
      data_d  = word.data;
      valid_d = 1'b1;
      comma_d = 1'b0;
      bc0_d   = word.bc0;
      crc_d   = word.is_crc;
    end else begin
      data_d  = COMMA_WORD;
      valid_d = 1'b0;
      comma_d = 1'b1;
      bc0_d   = 1'b0;
      crc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= COMMA_WORD;
      valid_q <= 1'b0;
      comma_q <= 1'b1;
      bc0_q   <= 1'b0;
      crc_q   <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      comma_q <= comma_d;
      bc0_q   <= bc0_d;
      crc_q   <= crc_d;
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign out_comma = comma_q;
  assign out_bc0   = bc0_q;
  assign out_crc   = crc_q;

endmodule

// File: rtl/crc_link_tx.sv
module crc_link_tx
  import crc_link_tx_pkg::*;
#(
  parameter int                FRAME_LEN   = 4,
  parameter int                FIFO_AW     = 3,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] COMMA_WORD  = 16'h50BC
) (
  input  logic              clk_s,
  input  logic              rst_s_n,
  input  logic              in_valid,
  input  logic              in_bc0,
  input  logic [DATA_W-1:0] in_data,
  input  logic              clk_f,
  input  logic              rst_f_n,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_comma,
  output logic              out_bc0,
  output logic              out_crc
);

  logic        srst_s_n, srst_f_n;
  logic        wr_en, wr_full, rd_en, rd_empty;
  link_word_t  wr_word, rd_word;
  logic [WORD_W-1:0] rd_bits;

  clt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_s (
    .clk(clk_s), .arst_n(rst_s_n), .srst_n(srst_s_n)
  );

  clt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_f (
    .clk(clk_f), .arst_n(rst_f_n), .srst_n(srst_f_n)
  );

  clt_framer #(.FRAME_LEN(FRAME_LEN)) u_framer (
    .clk(clk_s), .rst_n(srst_s_n),
    .in_valid(in_valid), .in_bc0(in_bc0), .in_data(in_data),
    .wr_en(wr_en), .wr_word(wr_word)
  );

  clt_async_fifo #(.DW(WORD_W), .AW(FIFO_AW), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
    .wclk(clk_s), .wrst_n(srst_s_n), .wr_en(wr_en), .wr_data(wr_word), .wr_full(wr_full),
    .rclk(clk_f), .rrst_n(srst_f_n), .rd_en(rd_en), .rd_data(rd_bits), .rd_empty(rd_empty)
  );

  assign rd_word = link_word_t'(rd_bits);

  clt_pad_out #(.COMMA_WORD(COMMA_WORD)) u_pad (
    .clk(clk_f), .rst_n(srst_f_n), .empty(rd_empty), .word(rd_word), .rd_en(rd_en),
    .out_data(out_data), .out_valid(out_valid), .out_comma(out_comma),
    .out_bc0(out_bc0), .out_crc(out_crc)
  );

endmodule

// File: rtl/clt_checker.sv
module clt_checker
  import crc_link_tx_pkg::*;
#(
  parameter logic [DATA_W-1:0] COMMA_WORD = 16'h50BC
) (
  input logic              clk_s,
  input logic              srst_s_n,
  input logic              clk_f,
  input logic              srst_f_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_is_crc,
  input logic              rd_empty,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_comma,
  input logic              out_bc0,
  input logic              out_crc
);

  a_r2_flag_exclusive: assert property (@(posedge clk_f) disable iff (!srst_f_n)
    out_valid != out_comma);

  a_r2_comma_word: assert property (@(posedge clk_f) disable iff (!srst_f_n)
    out_comma |-> out_data == COMMA_WORD);

  a_r6_bc0_on_data: assert property (@(posedge clk_f) disable iff (!srst_f_n)
    out_bc0 |-> (out_valid && !out_crc));

  a_r6_crc_on_valid: assert property (@(posedge clk_f) disable iff (!srst_f_n)
    out_crc |-> out_valid);

  a_r4_crc_after_data: assert property (@(posedge clk_s) disable iff (!srst_s_n)
    (wr_en && wr_is_crc) |-> $past(wr_en && !wr_is_crc));

  a_r10_no_overflow: assert property (@(posedge clk_s) disable iff (!srst_s_n)
    wr_en |-> !wr_full);

  a_r11_empty_pads: assert property (@(posedge clk_f) disable iff (!srst_f_n)
    rd_empty |=> out_comma);

endmodule

bind crc_link_tx clt_checker #(.COMMA_WORD(COMMA_WORD)) u_clt_chk (
  .clk_s(clk_s), .srst_s_n(srst_s_n), .clk_f(clk_f), .srst_f_n(srst_f_n),
  .wr_en(wr_en), .wr_full(wr_full), .wr_is_crc(wr_word.is_crc), .rd_empty(rd_empty),
  .out_data(out_data), .out_valid(out_valid), .out_comma(out_comma),
  .out_bc0(out_bc0), .out_crc(out_crc)
);

// File: tb/crc_link_tx_tb_top.sv
`timescale 1ns/1ps
module crc_link_tx_tb_top;

  localparam int          FLEN  = 4;
  localparam logic [15:0] COMMA = 16'h50BC;
  localparam int          NSTIM = 32;
  localparam int          WD_LIMIT = 100000;

  // {valid, bc0, data}
  localparam logic [17:0] STIM [NSTIM] = '{
    {2'b10, 16'h1111}, {2'b00, 16'h0000}, {2'b11, 16'hA001}, {2'b10, 16'hA002},
    {2'b10, 16'hA003}, {2'b10, 16'hA004}, {2'b10, 16'hDEAD}, {2'b11, 16'hB001},
    {2'b10, 16'hB002}, {2'b00, 16'h0000}, {2'b10, 16'hB003}, {2'b10, 16'hB004},
    {2'b11, 16'hEEEE}, {2'b10, 16'h2222}, {2'b11, 16'hC001}, {2'b10, 16'hC002},
    {2'b11, 16'hD001}, {2'b10, 16'hD002}, {2'b10, 16'hD003}, {2'b10, 16'hD004},
    {2'b00, 16'h0000}, {2'b11, 16'h0000}, {2'b10, 16'hFFFF}, {2'b10, 16'h8000},
    {2'b10, 16'h0001}, {2'b00, 16'h0000}, {2'b00, 16'h0000}, {2'b00, 16'h0000},
    {2'b00, 16'h0000}, {2'b00, 16'h0000}, {2'b00, 16'h0000}, {2'b00, 16'h0000}
  };

  logic clk_s = 1'b0, clk_f = 1'b0;
  logic rst_s_n = 1'b0, rst_f_n = 1'b0;
  logic in_valid = 1'b0, in_bc0 = 1'b0;
  logic [15:0] in_data = '0;
  logic [15:0] out_data;
  logic out_valid, out_comma, out_bc0, out_crc;

  always #6.5 clk_s = ~clk_s;
  always #4   clk_f = ~clk_f;

  crc_link_tx #(.FRAME_LEN(FLEN), .COMMA_WORD(COMMA)) dut_i (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .in_valid(in_valid), .in_bc0(in_bc0),
    .in_data(in_data), .clk_f(clk_f), .rst_f_n(rst_f_n), .out_data(out_data),
    .out_valid(out_valid), .out_comma(out_comma), .out_bc0(out_bc0), .out_crc(out_crc)
  );

  int checks = 0, errors = 0, cyc = 0, bad_flags = 0, n_rx = 0, n_exp = 0;
  bit cap_en = 1'b0, done = 1'b0;
  logic [17:0] rx [64];
  logic [17:0] ex [64];

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c ^ d;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk_f) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  always @(negedge clk_f) begin
    if (rst_f_n) begin
      if ((out_valid == out_comma) || (out_comma && out_data != COMMA)) bad_flags++;
      if (cap_en && out_valid) begin
        if (n_rx < 64) rx[n_rx] = {out_bc0, out_crc, out_data};
        n_rx++;
      end
    end
  end

  // expected stream built from the requirements (R3 R4 R5 R7 R8 R9)
  task automatic build_expected();
    bit open = 0, pend = 0;
    int cnt = 0;
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < NSTIM; i++) begin
      if (pend) begin
        ex[n_exp++] = {2'b01, c};
        pend = 0;
      end else if (STIM[i][17] && STIM[i][16]) begin
        ex[n_exp++] = {2'b10, STIM[i][15:0]};
        c = ref_crc(16'hFFFF, STIM[i][15:0]);
        cnt = 1;
        open = 1;
      end else if (STIM[i][17] && open) begin
        ex[n_exp++] = {2'b00, STIM[i][15:0]};
        c = ref_crc(c, STIM[i][15:0]);
        cnt++;
        if (cnt == FLEN) begin
          open = 0;
          pend = 1;
        end
      end
    end
  endtask

  initial begin
    build_expected();
    repeat (4) @(negedge clk_f);
    // R1: reset state while held
    check(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 0);
    check(out_comma == 1'b1, "R1 comma in reset", 32'(out_comma), 1);
    check(out_data == COMMA, "R1 data in reset", 32'(out_data), 32'(COMMA));
    @(negedge clk_s);
    rst_s_n = 1'b1;
    rst_f_n = 1'b1;
    repeat (6) @(negedge clk_f);
    check(out_comma && !out_valid, "R1 idle after reset", 32'(out_valid), 0);
    cap_en = 1'b1;
    repeat (3) @(negedge clk_s);
    for (int i = 0; i < NSTIM; i++) begin
      in_valid = STIM[i][17];
      in_bc0   = STIM[i][16];
      in_data  = STIM[i][15:0];
      @(negedge clk_s);
    end
    in_valid = 1'b0;
    in_bc0   = 1'b0;
    repeat (40) @(negedge clk_f);
    // R3 R4 R7 R8 R9: word count
    check(n_rx == n_exp, "R3 R7 R8 R9 word count", 32'(n_rx), 32'(n_exp));
    for (int i = 0; i < n_exp && i < 64; i++) begin
      // R3 data, R5 checksum, R6 flags
      check(i < n_rx && rx[i] == ex[i], "R3 R5 R6 word", 32'(rx[i]), 32'(ex[i]));
    end
    // R11: idle link returns to padding
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_f);
      check(out_comma && !out_valid && out_data == COMMA, "R11 padding when idle",
            32'(out_data), 32'(COMMA));
    end
    // R2: flag integrity over the whole run
    check(bad_flags == 0, "R2 comma flags", 32'(bad_flags), 0);
    // R1: reset asserted again mid-run
    @(negedge clk_s);
    in_valid = 1'b1;
    in_bc0   = 1'b1;
    in_data  = 16'h5A5A;
    @(negedge clk_s);
    rst_s_n = 1'b0;
    rst_f_n = 1'b0;
    in_valid = 1'b0;
    in_bc0   = 1'b0;
    @(negedge clk_f);
    check(!out_valid && out_comma && out_data == COMMA, "R1 reset reasserted",
          32'(out_data), 32'(COMMA));
    finish_run();
  end

endmodule